// File: doc/BRIEF.md
# SPI Register and Pipelined Parameter-RAM Port

This block is the serial host port of a device that holds a small bank of 8-bit control registers and a 16-bit-wide parameter RAM. It is an SPI slave in clock mode 0, oversampled by the system clock. Every access starts with a control byte and an address byte, followed by data bytes sent most significant bit first. Register accesses carry one data byte. RAM accesses carry two data bytes, high byte first. RAM reads are pipelined: the data clocked out during a RAM read belongs to the location named by the previous accepted RAM read.

After a hardware reset a sequential engine writes zero into every RAM word, one word per clock. A busy flag is raised during that sweep and for a short window after each RAM access is launched. A sticky flag shows that the sweep has finished. Both flags appear on output pins and in a read-only status register, so host software can poll them before touching RAM.

Chip select may be released after every byte, after every 16 bits, or held low across several accesses. The access position survives a release of chip select, so all three framings use the same decode. With `wide_frame` high, every register access is padded to 16-bit units: a read repeats its byte in both halves, and a write takes the first data byte and discards the second.

Top module: `spi_ramreg_port`

## Requirements
- R1: While reset is low and on the first cycle after it, `spi_miso` is 0, `ram_busy` is 1 and `clear_done` is 0. Every register reads 0 after reset.
- R2: A control byte with bit 5 set selects a register access, and bit 7 set means read. With `wide_frame` low the access is three bytes long (control, address, data). A write stores the data byte. A read returns the register on MISO during the third byte. Chip select may be released between bytes.
- R3: With `wide_frame` high a register access is four bytes long. A read returns the register value in both the third and the fourth byte. A write stores the third byte and ignores the fourth.
- R4: A control byte with bits 5 and 6 both clear selects a four-byte RAM access, with bit 7 set meaning read. A write stores {third byte, fourth byte} into the word named by the address byte once the fourth byte has been received.
- R5: During the third and fourth bytes of a RAM read, MISO carries the high and then the low byte of the word named by the previous accepted RAM read. The first RAM read after reset returns 0x0000.
- R6: `ram_busy` (status bit 0) is high for exactly RAM_DEPTH cycles after reset is released, and for exactly BUSY_CYCLES cycles after each accepted RAM access.
- R7: After reset the RAM sweep writes zero to every word. `clear_done` (status bit 4) rises when the sweep ends and stays high until the next reset. After the sweep with no access pending, the status register reads 0x10.
- R8: A RAM access whose last byte arrives while `ram_busy` is high is dropped. It does not write, does not update the read pipeline and does not extend the busy window. A status read during the sweep returns 0x01.
- R9: A control byte with bit 5 clear and bit 6 set is a no-op with the length of a register access. It changes no register and no RAM word, and MISO is 0 during its data bytes.
- R10: Writes to the status address (0x01) or to an address at or above REG_COUNT are ignored. Reads of addresses at or above REG_COUNT return 0. The top address REG_COUNT-1 is an ordinary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low hardware reset; starts the RAM sweep |
| wide_frame | input | 1 | 1 = register accesses padded to 16-bit units |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| spi_miso | output | 1 | Serial data to the host, MSB first |
| ram_busy | output | 1 | RAM sweep running or access window open |
| clear_done | output | 1 | RAM sweep finished since the last reset |

## Verification
The power-up sweep and a host-launched RAM access can both try to use the RAM port in the same cycle. To provoke this, the bench sends a RAM write at full serial speed straight after reset, so that its last byte lands while the sweep is still running. It then reads the status register, which is also still inside the sweep. The collision is judged in three ways: the busy run must still last exactly RAM_DEPTH cycles, the status read must return 0x01, and a later pipelined read of the targeted word must return zero.

// File: rtl/spi_ramreg_pkg.sv
package spi_ramreg_pkg;

    typedef enum logic [1:0] {
        XK_NOP = 2'd0,
        XK_REG = 2'd1,
        XK_RAM = 2'd2
    } xfer_kind_e;

    localparam int CTL_READ_BIT  = 7;
    localparam int CTL_NORAM_BIT = 6;
    localparam int CTL_REG_BIT   = 5;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_DONE_BIT = 4;

    function automatic xfer_kind_e decode_ctl(input logic [7:0] ctl);
        if (ctl[CTL_REG_BIT])
            return XK_REG;
        else if (ctl[CTL_NORAM_BIT])
            return XK_NOP;
        else
            return XK_RAM;
    endfunction

endpackage

// File: rtl/spi_link.sv
module spi_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);

    typedef struct packed {
        logic [2:0] sck;
        logic [1:0] csn;
        logic [1:0] sdi;
        logic [2:0] bit_cnt;
        logic [7:0] rx_sh;
        logic       rx_vld;
        logic [7:0] tx_sh;
    } link_t;

    link_t q, d;
    logic  rise, active;

    always_comb begin
        d        = q;
        d.sck    = {q.sck[1:0], sclk};
        d.csn    = {q.csn[0], cs_n};
        d.sdi    = {q.sdi[0], mosi};
        d.rx_vld = 1'b0;
        rise     = q.sck[1] & ~q.sck[2];
        active   = ~q.csn[1];
        if (!active) begin
            d.bit_cnt = 3'd0;
        end else if (rise) begin
            d.rx_sh = {q.rx_sh[6:0], q.sdi[1]};
            if (q.bit_cnt == 3'd7) begin
                d.bit_cnt = 3'd0;
                d.rx_vld  = 1'b1;
            end else begin
                d.bit_cnt = q.bit_cnt + 3'd1;
                d.tx_sh   = {q.tx_sh[6:0], 1'b0};
            end
        end
        if (tx_load)
            d.tx_sh = tx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign miso     = q.tx_sh[7];
    assign rx_valid = q.rx_vld;
    assign rx_byte  = q.rx_sh;

    // a completed byte is reported for one cycle only
    assert_rx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid)
        else $error("rx_valid held for two cycles");

    // a deselected link never reports a byte on the following cycle
    assert_idle_no_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !rx_valid) |=> !rx_valid)
        else $error("byte reported while deselected");

endmodule

// File: rtl/param_ram.sv
module param_ram #(
    parameter int DEPTH       = 256,
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rd_hold,
    output logic        busy,
    output logic        clear_done
);

    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic          clearing;
        logic          done;
        logic [IW-1:0] clr_idx;
        logic [CW-1:0] busy_cnt;
        logic [15:0]   hold;
    } ram_st_t;

    ram_st_t       q, d;
    logic [15:0]   mem [DEPTH];
    logic          mem_we;
    logic [IW-1:0] mem_wa;
    logic [15:0]   mem_wd;
    logic [IW-1:0] idx;
    logic          accept;

    assign idx    = addr[IW-1:0];
    assign busy   = q.clearing | (q.busy_cnt != '0);
    assign accept = go & ~busy;

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        mem_wa = idx;
        mem_wd = wdata;
        if (q.clearing) begin
            mem_we    = 1'b1;
            mem_wa    = q.clr_idx;
            mem_wd    = '0;
            d.clr_idx = q.clr_idx + 1'b1;
            if (q.clr_idx == IW'(DEPTH - 1)) begin
                d.clearing = 1'b0;
                d.done     = 1'b1;
            end
        end else if (accept) begin
            d.busy_cnt = CW'(BUSY_CYCLES);
            if (we)
                mem_we = 1'b1;
            else
                d.hold = mem[idx];
        end else if (q.busy_cnt != '0) begin
            d.busy_cnt = q.busy_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.clearing <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we)
            mem[mem_wa] <= mem_wd;
    end

    assign rd_hold    = q.hold;
    assign clear_done = q.done;

    assert_busy_until_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_done |-> busy)
        else $error("busy low before sweep finished");

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |=> clear_done)
        else $error("clear_done fell without reset");

    assert_launch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy)
        else $error("accepted access did not raise busy");

    assert_drop_keeps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy) |=> $stable(rd_hold))
        else $error("dropped access changed read pipeline");

endmodule

// File: rtl/ramreg_frame.sv
module ramreg_frame
    import spi_ramreg_pkg::*;
#(
    parameter int         REG_COUNT = 16,
    parameter logic [7:0] STAT_ADDR = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        tx_load,
    output logic [7:0]  tx_byte,
    output logic        ram_go,
    output logic        ram_we,
    output logic [7:0]  ram_addr,
    output logic [15:0] ram_wdata,
    input  logic [15:0] ram_hold,
    input  logic        ram_busy,
    input  logic        clear_done
);

    localparam int RW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    typedef struct packed {
        logic [1:0]                 idx;
        xfer_kind_e                 kind;
        logic                       rd;
        logic [7:0]                 addr;
        logic [7:0]                 hi;
        logic [15:0]                out_w;
        logic [REG_COUNT-1:0][7:0]  regs;
    } frame_t;

    frame_t     q, d;
    logic [7:0] stat_byte;
    logic [7:0] rd_val;
    logic [1:0] last_idx;
    logic       writable;

    always_comb begin
        stat_byte                = '0;
        stat_byte[STAT_BUSY_BIT] = ram_busy;
        stat_byte[STAT_DONE_BIT] = clear_done;
        if (rx_byte == STAT_ADDR)
            rd_val = stat_byte;
        else if (32'(rx_byte) < REG_COUNT)
            rd_val = q.regs[rx_byte[RW-1:0]];
        else
            rd_val = '0;
        writable = (32'(q.addr) < REG_COUNT) && (q.addr != STAT_ADDR);
        last_idx = (q.kind == XK_RAM || wide) ? 2'd3 : 2'd2;
    end

    always_comb begin
        d         = q;
        tx_load   = 1'b0;
        tx_byte   = '0;
        ram_go    = 1'b0;
        ram_we    = ~q.rd;
        ram_addr  = q.addr;
        ram_wdata = {q.hi, rx_byte};
        if (rx_valid) begin
            tx_load = 1'b1;
            unique case (q.idx)
                2'd0: begin
                    d.kind = decode_ctl(rx_byte);
                    d.rd   = rx_byte[CTL_READ_BIT];
                    d.idx  = 2'd1;
                end
                2'd1: begin
                    d.addr = rx_byte;
                    if (q.kind == XK_REG && q.rd)
                        d.out_w = {rd_val, rd_val};
                    else if (q.kind == XK_RAM && q.rd)
                        d.out_w = ram_hold;
                    else
                        d.out_w = '0;
                    tx_byte = d.out_w[15:8];
                    d.idx   = 2'd2;
                end
                2'd2: begin
                    d.hi    = rx_byte;
                    tx_byte = q.out_w[7:0];
                    if (q.kind == XK_REG && !q.rd && writable)
                        d.regs[q.addr[RW-1:0]] = rx_byte;
                    d.idx = (last_idx == 2'd2) ? 2'd0 : 2'd3;
                end
                default: begin
                    ram_go = (q.kind == XK_RAM);
                    d.idx  = 2'd0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    // register contents change only on a received byte
    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(q.regs))
        else $error("register bank changed without a byte");

    // a fourth byte position is reached only by RAM accesses or padded frames
    assert_fourth_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.idx == 2'd3) |-> (q.kind == XK_RAM || wide))
        else $error("unexpected fourth byte position");

    // the RAM side is only launched from a RAM-kind access
    assert_go_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_go |-> (q.kind == XK_RAM && rx_valid))
        else $error("RAM launched by non-RAM access");

endmodule

// File: rtl/spi_ramreg_port.sv
module spi_ramreg_port #(
    parameter int         REG_COUNT   = 16,
    parameter logic [7:0] STAT_ADDR   = 8'h01,
    parameter int         RAM_DEPTH   = 256,
    parameter int         BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wide_frame,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic ram_busy,
    output logic clear_done
);

    logic        rx_valid;
    logic [7:0]  rx_byte;
    logic        tx_load;
    logic [7:0]  tx_byte;
    logic        ram_go;
    logic        ram_we;
    logic [7:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_hold;

    spi_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    ramreg_frame #(
        .REG_COUNT (REG_COUNT),
        .STAT_ADDR (STAT_ADDR)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (wide_frame),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .ram_go     (ram_go),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_hold   (ram_hold),
        .ram_busy   (ram_busy),
        .clear_done (clear_done)
    );

    param_ram #(
        .DEPTH       (RAM_DEPTH),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (ram_go),
        .we         (ram_we),
        .addr       (ram_addr),
        .wdata      (ram_wdata),
        .rd_hold    (ram_hold),
        .busy       (ram_busy),
        .clear_done (clear_done)
    );

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear_done) |-> $past(ram_busy))
        else $error("sweep finished without busy");

endmodule

// File: tb/tb_spi_ramreg_port.sv
module tb_spi_ramreg_port;

    localparam int         HALF  = 2;
    localparam int         DEPTH = 256;
    localparam int         BUSYC = 4;
    localparam logic [7:0] STAT  = 8'h01;

    logic clk = 1'b0, rst_n = 1'b0, wide = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, busy, cdone;

    always #4 clk = ~clk;

    spi_ramreg_port dut (
        .clk(clk), .rst_n(rst_n), .wide_frame(wide), .spi_sclk(sclk),
        .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .ram_busy(busy), .clear_done(cdone)
    );

    int          total = 0, bad = 0;
    logic [7:0]  txb [4];
    logic [7:0]  rxb [4];
    logic [7:0]  m_reg [16];
    logic [15:0] m_ram [DEPTH];
    logic [15:0] m_hold;
    int          run_len = 0;
    bit          first_run = 1'b1;
    bit          finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference for the busy windows and the sweep flag (R6, R7)
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len   = 0;
            first_run = 1'b1;
        end else if (!finished) begin
            if (busy) run_len++;
            else if (run_len > 0) begin
                chk("R6 busy run length", run_len, first_run ? DEPTH : BUSYC);
                first_run = 1'b0;
                run_len   = 0;
            end
            chk("R7 clear_done per clock", 32'(cdone), 32'(!first_run));
        end
    end

    task automatic xfer(input int n, input int frame_k);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                mosi = txb[i][b];
                repeat (HALF) @(negedge clk);
                rxb[i][b] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
            if (frame_k != 0 && ((i + 1) % frame_k) == 0 && i < n - 1) begin
                cs_n = 1'b1;
                repeat (3) @(negedge clk);
                cs_n = 1'b0;
                repeat (3) @(negedge clk);
            end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [7:0] mval(input logic [7:0] a);
        return (32'(a) < 16 && a != STAT) ? m_reg[a[3:0]] : 8'h00;
    endfunction

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] v, input int frame_k);
        txb[0] = 8'h20; txb[1] = a; txb[2] = v; txb[3] = 8'hC3;
        xfer(wide ? 4 : 3, frame_k);
        if (32'(a) < 16 && a != STAT) m_reg[a[3:0]] = v;
    endtask

    task automatic reg_rd(input logic [7:0] a, input string req, input logic [7:0] expv, input int frame_k);
        txb[0] = 8'hA0; txb[1] = a; txb[2] = 8'h00; txb[3] = 8'h00;
        xfer(wide ? 4 : 3, frame_k);
        chk(req, 32'(rxb[2]), 32'(expv));
        if (wide) chk(req, 32'(rxb[3]), 32'(expv));
    endtask

    task automatic ram_wr(input logic [7:0] a, input logic [15:0] w);
        txb[0] = 8'h00; txb[1] = a; txb[2] = w[15:8]; txb[3] = w[7:0];
        xfer(4, 0);
        m_ram[a] = w;
    endtask

    task automatic ram_rd(input logic [7:0] a, input string req);
        txb[0] = 8'h80; txb[1] = a; txb[2] = 8'h00; txb[3] = 8'h00;
        xfer(4, 2);
        chk(req, 32'({rxb[2], rxb[3]}), 32'(m_hold));
        m_hold = m_ram[a];
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        for (int i = 0; i < DEPTH; i++) m_ram[i] = 16'h0000;
        m_hold = 16'h0000;
    endtask

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 miso after reset", 32'(miso), 32'd0);
        chk("R1 busy after reset", 32'(busy), 32'd1);
        chk("R1 clear_done after reset", 32'(cdone), 32'd0);

        // R8: RAM write landing inside the sweep is dropped (model unchanged)
        txb[0] = 8'h00; txb[1] = 8'h20; txb[2] = 8'hBE; txb[3] = 8'hEF;
        xfer(4, 0);
        reg_rd(STAT, "R8 status during sweep", 8'h01, 0);
        repeat (300) @(negedge clk);
        reg_rd(STAT, "R7 status after sweep", 8'h10, 0);
        reg_rd(8'h03, "R1 register reset value", 8'h00, 1);

        // R2: narrow register accesses, byte-framed and continuous
        reg_wr(8'h03, 8'hA5, 1);
        reg_wr(8'h05, 8'h3C, 0);
        reg_rd(8'h03, "R2 narrow read byte framed", mval(8'h03), 1);
        reg_rd(8'h05, "R2 narrow read continuous", mval(8'h05), 0);

        // R3: padded register accesses
        wide = 1'b1;
        reg_wr(8'h04, 8'h5A, 2);
        reg_rd(8'h04, "R3 wide read both halves", mval(8'h04), 2);
        reg_rd(8'h03, "R3 wide read continuous", mval(8'h03), 0);
        wide = 1'b0;

        // R10: protected and out-of-range addresses
        reg_wr(STAT, 8'hFF, 0);
        reg_rd(STAT, "R10 status write ignored", 8'h10, 0);
        reg_wr(8'h40, 8'h77, 0);
        reg_rd(8'h40, "R10 out of range reads zero", 8'h00, 0);
        reg_wr(8'h0F, 8'h99, 0);
        reg_rd(8'h0F, "R10 top register", mval(8'h0F), 0);

        // R9: no-op control byte
        txb[0] = 8'h40; txb[1] = 8'h03; txb[2] = 8'h00; txb[3] = 8'h00;
        xfer(3, 0);
        chk("R9 no-op MISO", 32'(rxb[2]), 32'd0);
        reg_rd(8'h03, "R9 register unchanged", mval(8'h03), 0);

        // R4, R5: RAM writes and pipelined reads
        ram_wr(8'h10, 16'h1234);
        ram_wr(8'h11, 16'hABCD);
        ram_wr(8'hFF, 16'h8001);
        ram_rd(8'h10, "R5 first read after reset");
        ram_rd(8'h11, "R5 pipelined read 0x10");
        ram_rd(8'h20, "R5 pipelined read 0x11");
        ram_rd(8'hFF, "R8 dropped write left zero");
        ram_rd(8'h10, "R4 top word written");
        ram_rd(8'h10, "R4 word 0x10 written");

        // R7: second reset clears RAM contents
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        ram_rd(8'h10, "R5 pipeline reset");
        ram_rd(8'h10, "R7 word cleared by sweep");
        reg_rd(8'h03, "R1 register cleared by reset", 8'h00, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule